// File: doc/BRIEF.md
# Accumulator Unary Operation Unit

This block carries out the single-operand accumulator operations of a small 8-bit processor datapath. Each cycle in which the issue strobe is high, the block decodes an 8-bit opcode and works out a new accumulator value from the current accumulator and carry. Where the operation calls for it, it also works out a new carry. The supported operations are clear, bitwise invert, nibble exchange, and rotations by one bit to the left or right. Each rotation comes in two forms: an 8-bit form, and a 9-bit form in which the carry flag is part of the ring.

The results are registered. One clock after the strobe, the block presents the new accumulator and carry, with a separate write strobe for each, so the surrounding register file can commit only the state the operation actually changes. An opcode outside the supported set raises an illegal flag for that one cycle and asserts no write strobe.

Top module: `acc_unary_unit`

## Requirements
- R1: Opcode 0xE4 produces an accumulator result of 0x00 with the accumulator write strobe high.
- R2: Opcode 0xF4 produces the bitwise complement of the accumulator with the accumulator write strobe high.
- R3: Opcode 0x23 rotates the accumulator left by one bit (bit 7 goes to bit 0). Opcode 0x03 rotates it right by one bit (bit 0 goes to bit 7).
- R4: Opcode 0x33 rotates left through the carry: the old carry goes into bit 0 and the old bit 7 becomes the new carry.
- R5: Opcode 0x13 rotates right through the carry: the old carry goes into bit 7 and the old bit 0 becomes the new carry.
- R6: Opcode 0xC4 exchanges bits 7:4 with bits 3:0 of the accumulator.
- R7: The carry write strobe is high only for opcodes 0x33 and 0x13. For every other opcode it is low.
- R8: Any opcode other than the seven listed above raises the illegal flag and asserts neither write strobe.
- R9: All outputs appear exactly one clock after the strobe and last for one cycle. With no strobe, both write strobes and the illegal flag are low in the next cycle.
- R10: After reset, both write strobes and the illegal flag are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue_i | input | 1 | Operation strobe |
| opcode_i | input | 8 | Operation code |
| acc_i | input | 8 | Current accumulator |
| cy_i | input | 1 | Current carry |
| acc_o | output | 8 | New accumulator value |
| cy_o | output | 1 | New carry value |
| acc_we_o | output | 1 | Accumulator write strobe |
| cy_we_o | output | 1 | Carry write strobe |
| illegal_o | output | 1 | Unsupported opcode flag |

## Verification
Every result, write strobe and illegal flag is due in the cycle right after the strobed cycle and in no other cycle. The bench's reference model pushes its prediction into a queue when it drives a strobe and pops it at the next edge. All outputs are compared every cycle, midway between edges. On idle cycles the model predicts that all strobes are low, which also checks that no result lasts longer than one cycle.

// File: rtl/acc_unary_pkg.sv
package acc_unary_pkg;
    localparam int DW = 8;
    localparam int HW = DW / 2;

    typedef enum logic [7:0] {
        OP_ZERO   = 8'hE4,
        OP_INVERT = 8'hF4,
        OP_ROL    = 8'h23,
        OP_ROLC   = 8'h33,
        OP_ROR    = 8'h03,
        OP_RORC   = 8'h13,
        OP_NIBX   = 8'hC4
    } op_code_e;

    typedef enum logic [2:0] {
        K_NONE, K_ZERO, K_INV, K_ROL, K_ROLC, K_ROR, K_RORC, K_NIBX
    } op_kind_e;

    typedef struct packed {
        logic [DW-1:0] acc;
        logic          cy;
        logic          acc_we;
        logic          cy_we;
        logic          illegal;
    } res_t;
endpackage

// File: rtl/acc_unary_decode.sv
module acc_unary_decode
    import acc_unary_pkg::*;
(
    input  logic [7:0] opcode_i,
    output op_kind_e   kind_o
);
    always_comb begin
        case (opcode_i)
            OP_ZERO:   kind_o = K_ZERO;
            OP_INVERT: kind_o = K_INV;
            OP_ROL:    kind_o = K_ROL;
            OP_ROLC:   kind_o = K_ROLC;
            OP_ROR:    kind_o = K_ROR;
            OP_RORC:   kind_o = K_RORC;
            OP_NIBX:   kind_o = K_NIBX;
            default:   kind_o = K_NONE;
        endcase
    end
endmodule

// File: rtl/acc_unary_exec.sv
module acc_unary_exec
    import acc_unary_pkg::*;
(
    input  op_kind_e      kind_i,
    input  logic [DW-1:0] acc_i,
    input  logic          cy_i,
    output logic [DW-1:0] acc_o,
    output logic          cy_o
);
    always_comb begin
        acc_o = acc_i;
        cy_o  = cy_i;
        unique case (kind_i)
            K_ZERO: acc_o = '0;
            K_INV:  acc_o = ~acc_i;
            K_ROL:  acc_o = {acc_i[DW-2:0], acc_i[DW-1]};
            K_ROR:  acc_o = {acc_i[0], acc_i[DW-1:1]};
            K_ROLC: begin
                acc_o = {acc_i[DW-2:0], cy_i};
                cy_o  = acc_i[DW-1];
            end
            K_RORC: begin
                acc_o = {cy_i, acc_i[DW-1:1]};
                cy_o  = acc_i[0];
            end
            K_NIBX: acc_o = {acc_i[HW-1:0], acc_i[DW-1:HW]};
            default: ;
        endcase
    end
endmodule

// File: rtl/acc_unary_unit.sv
module acc_unary_unit
    import acc_unary_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         issue_i,
    input  logic [7:0]   opcode_i,
    input  logic [7:0]   acc_i,
    input  logic         cy_i,
    output logic [7:0]   acc_o,
    output logic         cy_o,
    output logic         acc_we_o,
    output logic         cy_we_o,
    output logic         illegal_o
);
    op_kind_e      kind;
    logic [DW-1:0] ex_acc;
    logic          ex_cy;
    res_t          res_d, res_q;

    acc_unary_decode u_dec (.opcode_i(opcode_i), .kind_o(kind));
    acc_unary_exec   u_exe (.kind_i(kind), .acc_i(acc_i), .cy_i(cy_i),
                            .acc_o(ex_acc), .cy_o(ex_cy));

    always_comb begin
        res_d         = res_q;
        res_d.acc_we  = 1'b0;
        res_d.cy_we   = 1'b0;
        res_d.illegal = 1'b0;
        if (issue_i) begin
            if (kind == K_NONE) begin
                res_d.illegal = 1'b1;
            end else begin
                res_d.acc    = ex_acc;
                res_d.cy     = ex_cy;
                res_d.acc_we = 1'b1;
                res_d.cy_we  = (kind == K_ROLC) || (kind == K_RORC);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign acc_o     = res_q.acc;
    assign cy_o      = res_q.cy;
    assign acc_we_o  = res_q.acc_we;
    assign cy_we_o   = res_q.cy_we;
    assign illegal_o = res_q.illegal;
endmodule

// File: rtl/acc_unary_checker.sv
module acc_unary_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       issue_i,
    input logic [7:0] opcode_i,
    input logic [7:0] acc_i,
    input logic       cy_i,
    input logic [7:0] acc_o,
    input logic       cy_o,
    input logic       acc_we_o,
    input logic       cy_we_o,
    input logic       illegal_o
);
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_i |=> (!acc_we_o && !cy_we_o && !illegal_o));
    a_r8_illegal_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (!acc_we_o && !cy_we_o));
    a_r7_cy_we_needs_acc_we: assert property (@(posedge clk) disable iff (!rst_n)
        cy_we_o |-> acc_we_o);
    a_r1_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && opcode_i == 8'hE4) |=> (acc_we_o && acc_o == 8'h00 && !cy_we_o));
    a_r4_rolc: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && opcode_i == 8'h33) |=>
        (cy_we_o && cy_o == $past(acc_i[7]) && acc_o == {$past(acc_i[6:0]), $past(cy_i)}));
    a_r5_rorc: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && opcode_i == 8'h13) |=>
        (cy_we_o && cy_o == $past(acc_i[0]) && acc_o == {$past(cy_i), $past(acc_i[7:1])}));
endmodule

bind acc_unary_unit acc_unary_checker u_chk (.*);

// File: tb/acc_unary_unit_tb_top.sv
module acc_unary_unit_tb_top;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic issue_i = 1'b0, cy_i = 1'b0;
    logic [7:0] opcode_i = 8'h00, acc_i = 8'h00;
    logic [7:0] acc_o;
    logic cy_o, acc_we_o, cy_we_o, illegal_o;

    int vectors = 0, errors = 0;
    bit done = 0;
    logic [11:0] expq[$];   // {acc, cy, acc_we, cy_we, illegal}
    string tagq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_unary_unit dut_i (.*);

    function automatic logic [11:0] model(input logic v, input logic [7:0] op,
                                          input logic [7:0] a, input logic c);
        logic [7:0] r; logic rc;
        if (!v) return 12'h0;
        rc = c;
        case (op)
            8'hE4: r = 8'h00;
            8'hF4: r = 8'hFF ^ a;
            8'h23: r = (a * 2) % 256 + a / 128;
            8'h03: r = a / 2 + (a % 2) * 128;
            8'h33: begin r = (a * 2) % 256 + c; rc = a / 128; end
            8'h13: begin r = a / 2 + c * 128; rc = a % 2; end
            8'hC4: r = (a % 16) * 16 + a / 16;
            default: return 12'b000000000_001;
        endcase
        return {r, rc, 1'b1, (op == 8'h33 || op == 8'h13), 1'b0};
    endfunction

    function automatic string tag_of(input logic v, input logic [7:0] op);
        if (!v) return "R9";
        case (op)
            8'hE4: return "R1";  8'hF4: return "R2";
            8'h23, 8'h03: return "R3";
            8'h33: return "R4";  8'h13: return "R5";
            8'hC4: return "R6";
            default: return "R8";
        endcase
    endfunction

    function automatic void check_now();
        logic [11:0] e; string t;
        if (expq.size() == 0) return;
        e = expq.pop_front(); t = tagq.pop_front();
        vectors++;
        // R7: carry strobe, R8: no writes on illegal compared every time
        if (acc_we_o !== e[2] || cy_we_o !== e[1] || illegal_o !== e[0] ||
            (e[2] && acc_o !== e[11:4]) || (e[1] && cy_o !== e[3])) begin
            errors++;
            $display("FAIL %s/R7: got acc=%h cy=%b we=%b cwe=%b ill=%b exp acc=%h cy=%b we=%b cwe=%b ill=%b",
                     t, acc_o, cy_o, acc_we_o, cy_we_o, illegal_o,
                     e[11:4], e[3], e[2], e[1], e[0]);
        end
    endfunction

    task automatic step(input logic v, input logic [7:0] op,
                        input logic [7:0] a, input logic c);
        issue_i = v; opcode_i = op; acc_i = a; cy_i = c;
        expq.push_back(model(v, op, a, c));
        tagq.push_back(tag_of(v, op));
        @(posedge clk); #(CLK_PERIOD/2);
        check_now();
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            errors++; $display("FAIL watchdog");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] ops[7] = '{8'hE4, 8'hF4, 8'h23, 8'h03, 8'h33, 8'h13, 8'hC4};
        repeat (2) @(posedge clk);
        #(CLK_PERIOD/2);
        vectors++;
        if (acc_we_o !== 1'b0 || cy_we_o !== 1'b0 || illegal_o !== 1'b0) begin
            errors++; $display("FAIL R10: got we=%b cwe=%b ill=%b exp 0 0 0",
                               acc_we_o, cy_we_o, illegal_o);
        end
        rst_n = 1'b1;
        // directed corner cases
        step(1, 8'h33, 8'h80, 0);   // R4: bit7 to carry, 0x00
        step(1, 8'h33, 8'h00, 1);   // R4: carry into bit0
        step(1, 8'h13, 8'h01, 0);   // R5
        step(1, 8'h13, 8'h00, 1);   // R5: 0x80
        step(1, 8'h23, 8'h81, 0);   // R3
        step(1, 8'h03, 8'h81, 1);   // R3
        step(1, 8'hC4, 8'h5A, 0);   // R6
        step(1, 8'hE4, 8'hFF, 1);   // R1
        step(1, 8'hF4, 8'h3C, 0);   // R2
        step(0, 8'hE4, 8'h12, 1);   // R9: no strobe
        step(1, 8'h00, 8'h12, 1);   // R8
        step(1, 8'hE5, 8'h12, 1);   // R8
        step(1, 8'hE4, 8'h34, 0);   // back-to-back R9
        step(0, 8'h00, 8'h00, 0);
        for (int i = 0; i < 7; i++)
            for (int k = 0; k < 16; k++)
                step(1, ops[i], 8'(k * 37 + 11), k[0]);
        for (int k = 0; k < 256; k++)
            step(k % 5 != 0, 8'(k), 8'(k * 29), k[1]);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule